// File: doc/BRIEF.md
# Interrupt Pending Register and Priority Selector

This block holds the pending and enable state for a hart's interrupts. It also picks the single interrupt that should be taken next. Pending bits can be set or cleared one at a time by index. Local interrupt pins set pending bits directly, and a clear-all request wipes the whole pending vector together with a latched non-maskable interrupt. A software port writes and reads back both vectors whole. Every write is restricted to the bits the configuration implements.

Each cycle, a bit is a candidate only if its pending, enable and global-mask bits are all set. The global mask comes from outside the block, from the privilege and delegation logic. The selector ranks the candidates as follows:
- A latched non-maskable interrupt beats everything.
- Next come local interrupts, where the higher cause code wins.
- Last come the nine standard sources, in a fixed order.

The result is registered and presented as a valid flag, a 6-bit cause code and an NMI flag. A combinational "something is present" flag is also provided for the wake-up and stall logic.

The parameter `XLEN` chooses between 32-bit mode and 64-bit mode. In 32-bit mode, only local causes 16 to 31 exist. In 64-bit mode, local causes 16 to 63 exist.

Top module: `irq_prio_sel`

## Requirements
- R1: After reset, both vectors and the latched NMI are zero, `sel_valid` is low and `irq_present` is low.
- R2: `post_vld` sets pending bit `post_idx` and `clr_vld` clears pending bit `clr_idx`, both at the next clock edge. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R3: Local pin n sets pending bit 16+n. A pin whose bit would lie at or above XLEN has no effect.
- R4: `clr_all` zeroes the pending vector and the latched NMI. A set request in the same cycle (post, local pin or `nmi_req`) still takes effect.
- R5: Implemented bits are 0, 1, 3, 4, 5, 7, 8, 9, 11 and 16 up to XLEN-1. Software writes and set requests change only those bits, and every other bit reads zero. A software write to the pending vector is applied before clear-all, clear and set.
- R6: `irq_present` is high exactly when the latched NMI is set or (pending AND enable AND `gmask`) is nonzero.
- R7: Any local candidate wins over every standard candidate. Among local candidates, the highest cause code wins.
- R8: Among standard candidates, the order from first to last is 11, 3, 7, 9, 1, 5, 8, 0, 4.
- R9: A latched NMI is selected over all candidates and is reported with `sel_valid`=1, `sel_nmi`=1, `sel_cause`=0.
- R10: The selection outputs show the state of the previous cycle, one register after the pending and enable registers. With no candidate and no NMI, `sel_valid`, `sel_nmi` and `sel_cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_vld | input | 1 | Set request for one pending bit |
| post_idx | input | 6 | Bit index of the set request |
| clr_vld | input | 1 | Clear request for one pending bit |
| clr_idx | input | 6 | Bit index of the clear request |
| clr_all | input | 1 | Zero the pending vector and the latched NMI |
| local_irq | input | NUM_LOCAL | Local interrupt pins; pin n sets bit 16+n |
| nmi_req | input | 1 | Latch a non-maskable interrupt |
| csr_pend_we | input | 1 | Software write of the pending vector |
| csr_en_we | input | 1 | Software write of the enable vector |
| csr_wdata | input | 64 | Software write data |
| gmask | input | 64 | Global mask from privilege and delegation logic |
| csr_pend_rd | output | 64 | Pending vector read-back |
| csr_en_rd | output | 64 | Enable vector read-back |
| irq_present | output | 1 | Some interrupt can be taken now |
| sel_valid | output | 1 | Registered selection is valid |
| sel_nmi | output | 1 | Registered selection is the NMI |
| sel_cause | output | 6 | Registered cause code of the selection |

## Verification
The bench drives a 64-bit instance and a 32-bit instance side by side. It writes every pair of pending bits and checks the winner each time:
- A selector that inverted the local tie-break would report the lower local code.
- A selector that ranked standard sources by bit number would report, for example, cause 7 ahead of cause 3.
- A selector that ignored XLEN would let cause 40 win in 32-bit mode.

Mask sweeps move a single enable bit or global-mask bit across the vector. A design that left out one of the three terms would still select a masked source. The bench also drives a set and a clear to the same index in one cycle, and a set together with clear-all. If clear took priority, the bit would read back zero in either case. Finally, the bench posts an NMI while local interrupts are pending. A design without the NMI override would report a local cause, and one with the wrong clear-all handling would keep the NMI latched.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W      = 64;
  localparam int CAUSE_W    = 6;
  localparam int LOCAL_BASE = 16;
  localparam int NUM_STD    = 9;
  localparam int NO_RANK    = NUM_STD;

  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [VEC_W-1:0]   vec_t;

  typedef struct packed {
    logic   valid;
    logic   nmi;
    cause_t cause;
  } pick_t;

  // standard sources present in every configuration
  localparam vec_t STD_BITS = 64'h0000_0000_0000_0BBB;

  // standard sources, highest priority first
  localparam cause_t STD_RANK [NUM_STD] = '{
    6'd11, 6'd3, 6'd7, 6'd9, 6'd1, 6'd5, 6'd8, 6'd0, 6'd4
  };

  function automatic vec_t impl_bits(input int xlen);
    vec_t m;
    m = STD_BITS;
    for (int b = LOCAL_BASE; b < VEC_W; b++) begin
      if (b < xlen) m[b] = 1'b1;
    end
    return m;
  endfunction

  // position of a standard bit in the ranking, NO_RANK if absent
  function automatic int std_rank(input int bitpos);
    int r;
    r = NO_RANK;
    for (int k = NUM_STD - 1; k >= 0; k--) begin
      if (STD_RANK[k] == cause_t'(bitpos)) r = k;
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int NUM_LOCAL = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 post_vld,
  input  cause_t               post_idx,
  input  logic                 clr_vld,
  input  cause_t               clr_idx,
  input  logic                 clr_all,
  input  logic [NUM_LOCAL-1:0] local_irq,
  input  logic                 nmi_req,
  input  logic                 csr_pend_we,
  input  logic                 csr_en_we,
  input  vec_t                 csr_wdata,
  output vec_t                 pend_q,
  output vec_t                 en_q,
  output logic                 nmi_q
);
  localparam vec_t IMPL = impl_bits(XLEN);

  vec_t set_vec, clr_vec, pend_d, en_d;
  logic nmi_d, pend_ce, en_ce, nmi_ce;

  // set requests: local pins land at LOCAL_BASE + n
  always_comb begin
    set_vec = '0;
    for (int n = 0; n < NUM_LOCAL; n++) begin
      set_vec[LOCAL_BASE + n] = local_irq[n];
    end
    if (post_vld) set_vec[post_idx] = 1'b1;
    set_vec = set_vec & IMPL;
  end

  always_comb begin
    clr_vec = '0;
    if (clr_vld) clr_vec[clr_idx] = 1'b1;
  end

  // precedence: software write, clear-all, single clear, then sets
  always_comb begin
    pend_d = csr_pend_we ? (csr_wdata & IMPL) : pend_q;
    if (clr_all) pend_d = '0;
    pend_d = (pend_d & ~clr_vec) | set_vec;
    en_d   = csr_wdata & IMPL;
    nmi_d  = nmi_req | (nmi_q & ~clr_all);
  end

  assign pend_ce = csr_pend_we | clr_all | clr_vld | (|set_vec);
  assign en_ce   = csr_en_we;
  assign nmi_ce  = nmi_req | clr_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      nmi_q  <= 1'b0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (en_ce)   en_q   <= en_d;
      if (nmi_ce)  nmi_q  <= nmi_d;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
(
  input  vec_t  cand,
  input  logic  nmi,
  output pick_t pick
);
  logic   loc_hit, std_hit;
  cause_t loc_code, std_code;
  int     best_rank;

  // upstream masking keeps bits beyond XLEN at zero
  always_comb begin
    loc_hit  = 1'b0;
    loc_code = '0;
    for (int b = LOCAL_BASE; b < VEC_W; b++) begin
      if (cand[b]) begin
        loc_hit  = 1'b1;
        loc_code = cause_t'(b);
      end
    end
  end

  always_comb begin
    std_hit   = 1'b0;
    std_code  = '0;
    best_rank = NO_RANK;
    for (int b = 0; b < LOCAL_BASE; b++) begin
      if (cand[b] && (std_rank(b) < best_rank)) begin
        best_rank = std_rank(b);
        std_hit   = 1'b1;
        std_code  = cause_t'(b);
      end
    end
  end

  always_comb begin
    pick = '0;
    if (nmi) begin
      pick.valid = 1'b1;
      pick.nmi   = 1'b1;
    end else if (loc_hit) begin
      pick.valid = 1'b1;
      pick.cause = loc_code;
    end else if (std_hit) begin
      pick.valid = 1'b1;
      pick.cause = std_code;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int NUM_LOCAL = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 post_vld,
  input  logic [5:0]           post_idx,
  input  logic                 clr_vld,
  input  logic [5:0]           clr_idx,
  input  logic                 clr_all,
  input  logic [NUM_LOCAL-1:0] local_irq,
  input  logic                 nmi_req,
  input  logic                 csr_pend_we,
  input  logic                 csr_en_we,
  input  logic [63:0]          csr_wdata,
  input  logic [63:0]          gmask,
  output logic [63:0]          csr_pend_rd,
  output logic [63:0]          csr_en_rd,
  output logic                 irq_present,
  output logic                 sel_valid,
  output logic                 sel_nmi,
  output logic [5:0]           sel_cause
);
  localparam int MAX_LOCAL = VEC_W - LOCAL_BASE;

  logic  rst_int_n, nmi_q;
  vec_t  pend_q, en_q, cand;
  pick_t pick_d, pick_q;

  generate
    if ((XLEN != 32 && XLEN != 64) || NUM_LOCAL < 1 || NUM_LOCAL > MAX_LOCAL) begin : g_bad_cfg
      initial $error("irq_prio_sel: unsupported XLEN or NUM_LOCAL");
    end
  endgenerate

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_pend_reg #(.XLEN(XLEN), .NUM_LOCAL(NUM_LOCAL)) u_pend (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .post_vld    (post_vld),
    .post_idx    (post_idx),
    .clr_vld     (clr_vld),
    .clr_idx     (clr_idx),
    .clr_all     (clr_all),
    .local_irq   (local_irq),
    .nmi_req     (nmi_req),
    .csr_pend_we (csr_pend_we),
    .csr_en_we   (csr_en_we),
    .csr_wdata   (csr_wdata),
    .pend_q      (pend_q),
    .en_q        (en_q),
    .nmi_q       (nmi_q)
  );

  assign cand = pend_q & en_q & gmask;

  irq_prio_pick u_pick (
    .cand (cand),
    .nmi  (nmi_q),
    .pick (pick_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pick_q <= '0;
    else            pick_q <= pick_d;
  end

  assign irq_present = nmi_q | (|cand);
  assign csr_pend_rd = pend_q;
  assign csr_en_rd   = en_q;
  assign sel_valid   = pick_q.valid;
  assign sel_nmi     = pick_q.nmi;
  assign sel_cause   = pick_q.cause;
endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk
  import irq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        post_vld,
  input logic [5:0]  post_idx,
  input logic        clr_vld,
  input logic [5:0]  clr_idx,
  input logic        csr_pend_we,
  input logic [63:0] csr_pend_rd,
  input logic [63:0] csr_en_rd,
  input logic [63:0] gmask,
  input logic        irq_present,
  input logic        sel_valid,
  input logic        sel_nmi,
  input logic [5:0]  sel_cause
);
  localparam vec_t IMPL = impl_bits(XLEN);

  vec_t cand_q;
  logic present_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q    <= '0;
      present_q <= 1'b0;
    end else begin
      cand_q    <= csr_pend_rd & csr_en_rd & gmask;
      present_q <= irq_present;
    end
  end

  // R5
  impl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_pend_rd | csr_en_rd) & ~IMPL) == '0);

  // R2
  post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vld && IMPL[post_idx]) |=> csr_pend_rd[$past(post_idx)]);

  // R2
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !csr_pend_we && clr_idx < 6'd16 && !(post_vld && post_idx == clr_idx))
      |=> !csr_pend_rd[$past(clr_idx)]);

  // R10
  sel_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid == present_q);

  // R9
  nmi_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_nmi |-> (sel_valid && sel_cause == 6'd0));

  // R6
  cause_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_nmi) |-> cand_q[sel_cause]);
endmodule

bind irq_prio_sel irq_prio_sel_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .post_vld    (post_vld),
  .post_idx    (post_idx),
  .clr_vld     (clr_vld),
  .clr_idx     (clr_idx),
  .csr_pend_we (csr_pend_we),
  .csr_pend_rd (csr_pend_rd),
  .csr_en_rd   (csr_en_rd),
  .gmask       (gmask),
  .irq_present (irq_present),
  .sel_valid   (sel_valid),
  .sel_nmi     (sel_nmi),
  .sel_cause   (sel_cause)
);

// File: tb/test_irq_prio_sel.sv
`timescale 1ns/1ps
module test_irq_prio_sel;
  localparam int ORD [9] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        post_vld, clr_vld, clr_all, nmi_req, csr_pend_we, csr_en_we;
  logic [5:0]  post_idx, clr_idx;
  logic [47:0] loc_a;
  logic [19:0] loc_b;
  logic [63:0] csr_wdata, gmask;

  logic [63:0] pend_a, en_a, pend_b, en_b;
  logic        pres_a, val_a, nmi_a, pres_b, val_b, nmi_b;
  logic [5:0]  cause_a, cause_b;

  logic [63:0] mp_a, me_a, mp_b, me_b;
  logic        mn_a, mn_b;
  int          total = 0;
  int          bad   = 0;
  logic        done  = 1'b0;

  always #4 clk = ~clk;

  irq_prio_sel #(.XLEN(64), .NUM_LOCAL(48)) i_irq_prio_sel (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all), .local_irq(loc_a),
    .nmi_req(nmi_req), .csr_pend_we(csr_pend_we), .csr_en_we(csr_en_we),
    .csr_wdata(csr_wdata), .gmask(gmask), .csr_pend_rd(pend_a), .csr_en_rd(en_a),
    .irq_present(pres_a), .sel_valid(val_a), .sel_nmi(nmi_a), .sel_cause(cause_a)
  );

  irq_prio_sel #(.XLEN(32), .NUM_LOCAL(20)) i_irq_prio_sel_b (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all), .local_irq(loc_b),
    .nmi_req(nmi_req), .csr_pend_we(csr_pend_we), .csr_en_we(csr_en_we),
    .csr_wdata(csr_wdata), .gmask(gmask), .csr_pend_rd(pend_b), .csr_en_rd(en_b),
    .irq_present(pres_b), .sel_valid(val_b), .sel_nmi(nmi_b), .sel_cause(cause_b)
  );

  function automatic logic [63:0] impl(input int xl);
    return 64'h0BBB | ((xl == 64) ? 64'hFFFF_FFFF_FFFF_0000 : 64'h0000_0000_FFFF_0000);
  endfunction

  function automatic logic [63:0] nxt_pend(input int xl, input logic [63:0] p,
                                           input logic [63:0] locv);
    logic [63:0] r, s;
    r = csr_pend_we ? (csr_wdata & impl(xl)) : p;
    if (clr_all) r = '0;
    if (clr_vld) r[clr_idx] = 1'b0;
    s = locv;
    if (post_vld) s[post_idx] = 1'b1;
    return r | (s & impl(xl));
  endfunction

  function automatic logic [7:0] pick(input logic [63:0] c, input logic n);
    if (n) return 8'b1100_0000;
    for (int b = 63; b >= 16; b--) if (c[b]) return {2'b10, 6'(b)};
    for (int k = 0; k < 9; k++) if (c[ORD[k]]) return {2'b10, 6'(ORD[k])};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    post_vld = 0; clr_vld = 0; clr_all = 0; nmi_req = 0;
    csr_pend_we = 0; csr_en_we = 0; loc_a = '0; loc_b = '0;
  endtask

  // one clock: model follows the requirements, outputs compared mid-cycle
  task automatic cyc(input string tag);
    logic [7:0] ea, eb;
    logic [63:0] na, nb;
    @(posedge clk);
    ea = pick(mp_a & me_a & gmask, mn_a);
    eb = pick(mp_b & me_b & gmask, mn_b);
    na = nxt_pend(64, mp_a, {loc_a, 16'h0});
    nb = nxt_pend(32, mp_b, {28'h0, loc_b, 16'h0});
    if (csr_en_we) begin
      me_a = csr_wdata & impl(64);
      me_b = csr_wdata & impl(32);
    end
    mn_a = nmi_req | (mn_a & ~clr_all);
    mn_b = nmi_req | (mn_b & ~clr_all);
    mp_a = na;
    mp_b = nb;
    @(negedge clk);
    chk(tag, "pend64", pend_a, mp_a);
    chk(tag, "pend32", pend_b, mp_b);
    chk(tag, "en64", en_a, me_a);
    chk(tag, "en32", en_b, me_b);
    chk(tag, "sel64", {56'h0, val_a, nmi_a, cause_a}, {56'h0, ea});
    chk(tag, "sel32", {56'h0, val_b, nmi_b, cause_b}, {56'h0, eb});
    chk(tag, "present64", {63'h0, pres_a}, {63'h0, mn_a | (|(mp_a & me_a & gmask))});
    chk(tag, "present32", {63'h0, pres_b}, {63'h0, mn_b | (|(mp_b & me_b & gmask))});
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_inputs(); post_idx = 0; clr_idx = 0;
    csr_wdata = '0; gmask = '0;
    mp_a = '0; me_a = '0; mp_b = '0; me_b = '0; mn_a = 0; mn_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "pend", pend_a | pend_b, 64'h0);
    chk("R1", "en", en_a | en_b, 64'h0);
    chk("R1", "sel_valid", {63'h0, val_a | val_b}, 64'h0);
    chk("R1", "present", {63'h0, pres_a | pres_b}, 64'h0);
    rst_n = 1;
    repeat (4) cyc("R1");

    // R5: enable write masked to implemented bits
    gmask = '1; csr_wdata = '1; csr_en_we = 1; cyc("R5");
    csr_wdata = '1; csr_pend_we = 1; cyc("R5");
    cyc("R5");

    // R7 R8: every pair of pending bits
    for (int i = 0; i < 64; i++) begin
      for (int j = i; j < 64; j++) begin
        csr_wdata = (64'd1 << i) | (64'd1 << j);
        csr_pend_we = 1;
        cyc((i >= 16 || j >= 16) ? "R7" : "R8");
        cyc((i >= 16 || j >= 16) ? "R7" : "R8");
      end
    end

    // R6: single global mask bit, then single enable bit
    csr_wdata = '1; csr_pend_we = 1; cyc("R6");
    for (int k = 0; k < 64; k++) begin
      gmask = 64'd1 << k; cyc("R6"); cyc("R6");
    end
    gmask = '1;
    for (int k = 0; k < 64; k++) begin
      csr_wdata = 64'd1 << k; csr_en_we = 1; cyc("R6"); cyc("R6");
    end
    csr_wdata = '1; csr_en_we = 1; cyc("R6");

    // R3: local pins one at a time, pins past XLEN ignored
    clr_all = 1; cyc("R4");
    for (int n = 0; n < 48; n++) begin
      loc_a = 48'd1 << n;
      loc_b = (n < 20) ? (20'd1 << n) : 20'd0;
      cyc("R3"); cyc("R3");
      clr_all = 1; cyc("R3");
    end

    // R2: post then clear each index, then set and clear together
    for (int k = 0; k < 64; k++) begin
      post_vld = 1; post_idx = 6'(k); cyc("R2");
      clr_vld = 1; clr_idx = 6'(k); cyc("R2");
      post_vld = 1; clr_vld = 1; post_idx = 6'(k); clr_idx = 6'(k); cyc("R2");
      cyc("R2");
    end

    // R4: clear-all with a simultaneous post
    clr_all = 1; post_vld = 1; post_idx = 6'd11; cyc("R4");
    cyc("R4");

    // R9: NMI over pending locals, then clear-all drops it
    loc_a = 48'h0000_0000_0003; loc_b = 20'h3; cyc("R9");
    nmi_req = 1; cyc("R9"); cyc("R9"); cyc("R9");
    clr_all = 1; cyc("R4"); cyc("R4");

    // R10: registered selection lags, empty selection is all zero
    clr_all = 1; cyc("R10");
    post_vld = 1; post_idx = 6'd3; cyc("R10");
    cyc("R10");
    csr_wdata = '0; csr_en_we = 1; cyc("R10"); cyc("R10");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule